// File: doc/BRIEF.md
# I2C Bit-Level Bus Timing Generator

This block generates the SCL and SDA waveforms for an I2C host. It runs on a 16 MHz internal clock, and every count it uses is a number of those clock cycles. A byte-level engine sits above it and passes it one bit-level request at a time: START, repeated START, STOP, write one bit, or read one bit. For each request the block drives the two open-drain enables through the right sequence of phases. It pulses `done_o` for one cycle when the request is complete.

The SCL waveform has two separate counts, one for the high level and one for the low level. Both are packed into a single 16-bit clock word. Three more counts set the START hold time, the repeated-START setup time and the STOP setup time. A clock word of zero switches SCL generation off. The default word is 0x1B0E: a 27-cycle low level plus a 14-cycle high level gives a 41-cycle period, close to 400 kHz. Condition counts of about 0x0A suit fast mode. Standard mode needs about 0x47 for the START hold and 0x50 for the repeated-START setup.

Top module: `i2c_scl_timing`

## Requirements
- R1: After reset, both line enables are low (SCL and SDA released), and `done_o`, `busy_o` and `rx_bit_o` are 0.
- R2: The SCL high count is clock-word bits 6:0 and the SCL low count is bits 14:8. Each phase lasts exactly its count in cycles, and a count of 0 lasts one cycle. With word 0x1B0E, a written bit shows 27 cycles with SCL low, then 14 cycles with SCL high.
- R3: START (op code 0) pulls SDA low with SCL released for the START hold count. It then pulls SCL low for the low count and ends with both lines driven low.
- R4: Repeated START (op code 1) first releases SDA with SCL low for the low count. It then releases SCL for the repeated-START setup count, pulls SDA low for the START hold count, then pulls SCL low for the low count.
- R5: STOP (op code 2) drives SDA low with SCL low for the low count. It then releases SCL for the STOP setup count, and finally releases SDA, leaving both lines released.
- R6: Write bit (op code 3, value on `req_bit_i`) puts the bit on SDA with SCL low for the low count and keeps it there with SCL high for the high count. It ends with SCL pulled low and SDA unchanged.
- R7: Read bit (op code 4) releases SDA, holds SCL low for the low count and high for the high count, and ends with SCL low. `rx_bit_o` takes `sda_i` at the rising edge of SCL and holds it until the next read.
- R8: Each accepted request ends with `done_o` high for exactly one cycle. `busy_o` is high from the cycle after acceptance until `done_o` rises, and is low while `done_o` is high.
- R9: While the clock word is zero, every request is ignored: no `done_o`, and the line enables do not change.
- R10: A request is ignored if it arrives while `busy_o` is high, or if it carries an op code of 5 to 7. The ongoing sequence is not disturbed.
- R11: During a write-bit or read-bit request, SDA never changes while SCL is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 16 MHz internal clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clk_word_i | input | 16 | Packed SCL counts: high in 6:0, low in 14:8 |
| start_hold_i | input | 8 | START hold count |
| rstart_setup_i | input | 8 | Repeated-START setup count |
| stop_setup_i | input | 8 | STOP setup count |
| req_valid_i | input | 1 | Request strobe |
| req_op_i | input | 3 | Request op code (0 start, 1 repeated start, 2 stop, 3 write, 4 read) |
| req_bit_i | input | 1 | Bit value for a write request |
| sda_i | input | 1 | Sensed SDA line level |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| rx_bit_o | output | 1 | Last bit sampled by a read |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench records every line-enable run from acceptance to `done_o` and compares it with the expected run list. A phase that is one cycle too long or too short, or a count of zero that is not raised to one cycle, gives a mismatched run length. Swapping the high and low fields of the clock word, or using the wrong setup count for STOP versus repeated START, shows up the same way. Requests with a zero clock word, requests that arrive while busy, and unused op codes are issued on purpose. A design that accepted any of them would move the lines or emit a stray `done_o`. Sampling the read bit at the wrong edge is caught because `sda_i` is set differently in each read, and a later write changes `sda_i` again to show that the read bit is held.

// File: rtl/i2c_tg_pkg.sv
package i2c_tg_pkg;
  typedef enum logic [2:0] {
    OP_START  = 3'd0,
    OP_RSTART = 3'd1,
    OP_STOP   = 3'd2,
    OP_WRITE  = 3'd3,
    OP_READ   = 3'd4
  } tg_op_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE_LOW,   // SCL low, SDA set for the request
    PH_SETUP,     // SCL released, condition setup wait
    PH_HOLD,      // SCL released, SDA low (start hold)
    PH_POST_LOW,  // SCL low after a start condition
    PH_HIGH       // SCL released, data valid
  } tg_phase_e;

  typedef struct packed {
    logic scl_oe;
    logic sda_oe;
  } tg_lines_t;
endpackage

// File: rtl/tg_clk_fields.sv
module tg_clk_fields #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 7,
  parameter int HI_LSB = 0,
  parameter int LO_LSB = 8
) (
  input  logic [WORD_W-1:0] word_i,
  output logic [CNT_W-1:0]  hi_cnt_o,
  output logic [CNT_W-1:0]  lo_cnt_o,
  output logic              off_o
);
  assign hi_cnt_o = word_i[HI_LSB +: CNT_W];
  assign lo_cnt_o = word_i[LO_LSB +: CNT_W];
  assign off_o    = (word_i == '0);
endmodule

// File: rtl/tg_timer.sv
module tg_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  // a length of N gives N cycles; zero is treated as one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= (len_i == '0) ? '0 : len_i - 1'b1;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/tg_seq.sv
module tg_seq
  import i2c_tg_pkg::*;
#(
  parameter int TMR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             off_i,
  input  logic [TMR_W-1:0] hi_len_i,
  input  logic [TMR_W-1:0] lo_len_i,
  input  logic [TMR_W-1:0] hold_len_i,
  input  logic [TMR_W-1:0] rsu_len_i,
  input  logic [TMR_W-1:0] psu_len_i,
  input  logic             req_valid_i,
  input  logic [2:0]       req_op_i,
  input  logic             req_bit_i,
  input  logic             sda_i,
  input  logic             expired_i,
  output logic             load_o,
  output logic [TMR_W-1:0] len_o,
  output tg_lines_t        lines_o,
  output logic             rx_bit_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             data_op_o
);
  tg_phase_e ph_q, tgt_ph;
  tg_op_e    op_q, op_sel;
  logic      bit_q, bit_sel;
  tg_lines_t lines_q, lines_d;
  logic      idle, op_ok, accept, advance;

  assign idle   = (ph_q == PH_IDLE);
  assign op_ok  = (req_op_i <= 3'd4);
  assign accept = idle && req_valid_i && !off_i && op_ok;
  assign op_sel  = idle ? tg_op_e'(req_op_i) : op_q;
  assign bit_sel = idle ? req_bit_i : bit_q;
  assign advance = idle ? accept : expired_i;

  always_comb begin
    tgt_ph = PH_IDLE;
    if (idle) begin
      tgt_ph = (op_sel == OP_START) ? PH_HOLD : PH_PRE_LOW;
    end else begin
      unique case (ph_q)
        PH_HOLD:     tgt_ph = PH_POST_LOW;
        PH_POST_LOW: tgt_ph = PH_IDLE;
        PH_PRE_LOW:  tgt_ph = (op_q == OP_WRITE || op_q == OP_READ) ? PH_HIGH : PH_SETUP;
        PH_SETUP:    tgt_ph = (op_q == OP_STOP) ? PH_IDLE : PH_HOLD;
        PH_HIGH:     tgt_ph = PH_IDLE;
        default:     tgt_ph = PH_IDLE;
      endcase
    end
  end

  always_comb begin
    len_o = lo_len_i;
    unique case (tgt_ph)
      PH_HIGH:  len_o = hi_len_i;
      PH_HOLD:  len_o = hold_len_i;
      PH_SETUP: len_o = (op_sel == OP_STOP) ? psu_len_i : rsu_len_i;
      default:  len_o = lo_len_i;
    endcase
  end

  assign load_o = advance && (tgt_ph != PH_IDLE);

  always_comb begin
    lines_d = lines_q;
    unique case (tgt_ph)
      PH_HOLD:     lines_d = '{scl_oe: 1'b0, sda_oe: 1'b1};
      PH_POST_LOW: lines_d = '{scl_oe: 1'b1, sda_oe: 1'b1};
      PH_SETUP,
      PH_HIGH:     lines_d.scl_oe = 1'b0;
      PH_PRE_LOW: begin
        lines_d.scl_oe = 1'b1;
        unique case (op_sel)
          OP_STOP:  lines_d.sda_oe = 1'b1;
          OP_WRITE: lines_d.sda_oe = ~bit_sel;
          default:  lines_d.sda_oe = 1'b0;
        endcase
      end
      default: begin
        // end of request
        unique case (op_sel)
          OP_STOP:            lines_d = '{scl_oe: 1'b0, sda_oe: 1'b0};
          OP_WRITE, OP_READ:  lines_d.scl_oe = 1'b1;
          default:            lines_d = lines_q;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q     <= PH_IDLE;
      op_q     <= OP_START;
      bit_q    <= 1'b0;
      lines_q  <= '0;
      done_o   <= 1'b0;
      rx_bit_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (accept) begin
        op_q  <= op_sel;
        bit_q <= req_bit_i;
      end
      if (advance) begin
        ph_q    <= tgt_ph;
        lines_q <= lines_d;
        done_o  <= (tgt_ph == PH_IDLE);
        if (tgt_ph == PH_HIGH && op_sel == OP_READ) rx_bit_o <= sda_i;
      end
    end
  end

  assign lines_o   = lines_q;
  assign busy_o    = !idle;
  assign data_op_o = !idle && (op_q == OP_WRITE || op_q == OP_READ);
endmodule

// File: rtl/i2c_scl_timing.sv
module i2c_scl_timing
  import i2c_tg_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 7,
  parameter int HI_LSB = 0,
  parameter int LO_LSB = 8,
  parameter int COND_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] clk_word_i,
  input  logic [COND_W-1:0] start_hold_i,
  input  logic [COND_W-1:0] rstart_setup_i,
  input  logic [COND_W-1:0] stop_setup_i,
  input  logic              req_valid_i,
  input  logic [2:0]        req_op_i,
  input  logic              req_bit_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic              rx_bit_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int TMR_W = (CNT_W > COND_W) ? CNT_W : COND_W;

  logic [CNT_W-1:0] hi_cnt, lo_cnt;
  logic             clk_off;
  logic             tmr_load, tmr_exp;
  logic [TMR_W-1:0] tmr_len;
  tg_lines_t        lines;
  logic             data_op;

  tg_clk_fields #(
    .WORD_W(WORD_W), .CNT_W(CNT_W), .HI_LSB(HI_LSB), .LO_LSB(LO_LSB)
  ) u_fields (
    .word_i  (clk_word_i),
    .hi_cnt_o(hi_cnt),
    .lo_cnt_o(lo_cnt),
    .off_o   (clk_off)
  );

  tg_timer #(.W(TMR_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (tmr_load),
    .len_i    (tmr_len),
    .expired_o(tmr_exp)
  );

  tg_seq #(.TMR_W(TMR_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .off_i      (clk_off),
    .hi_len_i   (TMR_W'(hi_cnt)),
    .lo_len_i   (TMR_W'(lo_cnt)),
    .hold_len_i (TMR_W'(start_hold_i)),
    .rsu_len_i  (TMR_W'(rstart_setup_i)),
    .psu_len_i  (TMR_W'(stop_setup_i)),
    .req_valid_i(req_valid_i),
    .req_op_i   (req_op_i),
    .req_bit_i  (req_bit_i),
    .sda_i      (sda_i),
    .expired_i  (tmr_exp),
    .load_o     (tmr_load),
    .len_o      (tmr_len),
    .lines_o    (lines),
    .rx_bit_o   (rx_bit_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .data_op_o  (data_op)
  );

  assign scl_oe_o = lines.scl_oe;
  assign sda_oe_o = lines.sda_oe;
endmodule

// File: rtl/i2c_scl_timing_chk.sv
module i2c_scl_timing_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [WORD_W-1:0] clk_word_i,
  input logic              req_valid_i,
  input logic              scl_oe_o,
  input logic              sda_oe_o,
  input logic              rx_bit_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              data_op
);
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_not_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_zero_word_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_valid_i && clk_word_i == '0) |=> (!busy_o && !done_o));

  assert_rx_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(rx_bit_o));

  assert_sda_stable_high_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_op && !scl_oe_o && $past(!scl_oe_o)) |-> (sda_oe_o == $past(sda_oe_o)));
endmodule

bind i2c_scl_timing i2c_scl_timing_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clk_word_i (clk_word_i),
  .req_valid_i(req_valid_i),
  .scl_oe_o   (scl_oe_o),
  .sda_oe_o   (sda_oe_o),
  .rx_bit_o   (rx_bit_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .data_op    (data_op)
);

// File: tb/i2c_scl_timing_tb_top.sv
module i2c_scl_timing_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_SEG    = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] clk_word = 16'h1B0E;
  logic [7:0]  t_hold = 8'h0A, t_rsu = 8'h0A, t_psu = 8'h0A;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = 3'd0;
  logic        req_bit = 1'b0;
  logic        sda_in = 1'b1;
  logic        scl_oe, sda_oe, rx_bit, busy, done;

  int checks = 0;
  int errors = 0;

  int   e_n, o_n;
  logic e_scl [MAX_SEG];
  logic e_sda [MAX_SEG];
  int   e_len [MAX_SEG];
  logic o_scl [MAX_SEG];
  logic o_sda [MAX_SEG];
  int   o_len [MAX_SEG];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_scl_timing dut_i (
    .clk_i(clk), .rst_ni(rst_n), .clk_word_i(clk_word),
    .start_hold_i(t_hold), .rstart_setup_i(t_rsu), .stop_setup_i(t_psu),
    .req_valid_i(req_valid), .req_op_i(req_op), .req_bit_i(req_bit),
    .sda_i(sda_in), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
    .rx_bit_o(rx_bit), .busy_o(busy), .done_o(done)
  );

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic int m1(input int n);
    return (n == 0) ? 1 : n;
  endfunction

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic add_seg(input logic s, input logic d, input int n);
    e_scl[e_n] = s; e_sda[e_n] = d; e_len[e_n] = m1(n); e_n++;
  endtask

  // expected enable runs (1 = line pulled low) and the final state
  task automatic build_exp(input logic [2:0] op, input logic b,
                           output logic f_scl, output logic f_sda);
    int lo, hi;
    lo = clk_word[14:8];
    hi = clk_word[6:0];
    e_n = 0;
    case (op)
      3'd0: begin add_seg(0,1,t_hold); add_seg(1,1,lo); f_scl = 1; f_sda = 1; end
      3'd1: begin add_seg(1,0,lo); add_seg(0,0,t_rsu); add_seg(0,1,t_hold);
                  add_seg(1,1,lo); f_scl = 1; f_sda = 1; end
      3'd2: begin add_seg(1,1,lo); add_seg(0,1,t_psu); f_scl = 0; f_sda = 0; end
      3'd3: begin add_seg(1,~b,lo); add_seg(0,~b,hi); f_scl = 1; f_sda = ~b; end
      default: begin add_seg(1,0,lo); add_seg(0,0,hi); f_scl = 1; f_sda = 0; end
    endcase
  endtask

  task automatic run_req(input logic [2:0] op, input logic b, input logic sd,
                         input bit inject);
    logic f_scl, f_sda, seg_ok, busy_ok;
    int   cyc;
    string tag;
    tag = op_tag(op);
    build_exp(op, b, f_scl, f_sda);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_bit = b; sda_in = sd;
    o_n = 0; cyc = 0; busy_ok = 1'b1;
    forever begin
      @(negedge clk);
      if (cyc == 0) req_valid = 1'b0;
      if (inject && cyc == 2) begin req_valid = 1'b1; req_op = 3'd2; end
      if (inject && cyc == 3) req_valid = 1'b0;
      if (done || cyc > 4000) break;
      if (!busy) busy_ok = 1'b0;
      if (o_n > 0 && o_scl[o_n-1] == scl_oe && o_sda[o_n-1] == sda_oe) o_len[o_n-1]++;
      else if (o_n < MAX_SEG) begin
        o_scl[o_n] = scl_oe; o_sda[o_n] = sda_oe; o_len[o_n] = 1; o_n++;
      end
      cyc++;
    end
    seg_ok = (o_n == e_n);
    for (int i = 0; i < e_n; i++)
      if (seg_ok && (o_scl[i] != e_scl[i] || o_sda[i] != e_sda[i] || o_len[i] != e_len[i]))
        seg_ok = 1'b0;
    check(seg_ok, inject ? "R10" : tag, "phase runs (R2 counts)", o_n, e_n);
    if (!seg_ok)
      for (int i = 0; i < o_n; i++)
        $display("  seg %0d: scl_oe=%0b sda_oe=%0b len=%0d", i, o_scl[i], o_sda[i], o_len[i]);
    if (op == 3'd3 || op == 3'd4) check(seg_ok, "R11", "sda stable with scl high", o_n, e_n);
    check(scl_oe == f_scl && sda_oe == f_sda, tag, "final lines",
          {scl_oe, sda_oe}, {f_scl, f_sda});
    check(done && !busy && busy_ok, "R8", "done/busy framing", {done, busy, busy_ok}, 3'b101);
    if (op == 3'd4) check(rx_bit == sd, "R7", "sampled bit", rx_bit, sd);
    @(negedge clk);
    check(!done, "R8", "done one cycle", done, 0);
  endtask

  task automatic check_ignored(input logic [2:0] op, input string tag);
    logic s0, d0;
    int   seen;
    @(negedge clk);
    s0 = scl_oe; d0 = sda_oe;
    req_valid = 1'b1; req_op = op; req_bit = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    seen = 0;
    for (int i = 0; i < 30; i++) begin
      if (done || busy || scl_oe != s0 || sda_oe != d0) seen++;
      @(negedge clk);
    end
    check(seen == 0, tag, "request ignored", seen, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(!scl_oe && !sda_oe && !done && !busy && !rx_bit, "R1", "reset state",
          {scl_oe, sda_oe, done, busy, rx_bit}, 0);
    rst_n = 1'b1;

    // default word: 27 low + 14 high
    run_req(3'd0, 0, 1, 0);
    run_req(3'd3, 1, 1, 0);
    check(e_len[0] + e_len[1] == 41, "R2", "default period", e_len[0] + e_len[1], 41);
    run_req(3'd4, 0, 1, 0);
    run_req(3'd3, 0, 0, 0);
    check(rx_bit == 1'b1, "R7", "read bit held", rx_bit, 1);
    run_req(3'd1, 0, 1, 0);
    run_req(3'd2, 0, 1, 0);

    // standard-mode condition counts
    t_hold = 8'h47; t_rsu = 8'h50;
    run_req(3'd0, 0, 1, 0);
    run_req(3'd1, 0, 1, 0);
    run_req(3'd2, 0, 1, 0);

    // zero counts last one cycle
    clk_word = 16'h0100; t_hold = 8'h00; t_rsu = 8'h00; t_psu = 8'h00;
    run_req(3'd0, 0, 1, 0);
    run_req(3'd4, 0, 0, 0);
    run_req(3'd1, 0, 1, 0);
    run_req(3'd2, 0, 1, 0);

    // zero word and bad op codes are ignored
    clk_word = 16'h0000;
    check_ignored(3'd0, "R9");
    check_ignored(3'd3, "R9");
    clk_word = 16'h1B0E; t_hold = 8'h0A; t_rsu = 8'h0A; t_psu = 8'h0A;
    check_ignored(3'd5, "R10");
    check_ignored(3'd7, "R10");

    // request while busy
    run_req(3'd0, 0, 1, 1);
    run_req(3'd3, 1, 1, 1);

    for (int it = 0; it < 80; it++) begin
      clk_word = {1'b0, 7'($urandom_range(0, 20)), 1'b0, 7'($urandom_range(0, 20))};
      if (clk_word == 16'h0) clk_word = 16'h0101;
      t_hold = 8'($urandom_range(0, 20));
      t_rsu  = 8'($urandom_range(0, 20));
      t_psu  = 8'($urandom_range(0, 20));
      run_req(3'($urandom_range(0, 4)), 1'($urandom), 1'($urandom), 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule